// File: doc/BRIEF.md
# NAND bus strobe timing generator

This block turns single-byte transfer requests into correctly timed read-enable, write-enable and chip-enable strobes for an 8-bit parallel NAND bus. The width of every strobe phase comes from a packed timing word: the low and high parts of a write strobe, the low and high parts of a read strobe, a chip-enable setup delay, a bus turnaround gap and a busy hold-off. Each phase lasts its field value plus one clock, so a zero field still yields a one-cycle phase.

The timing word and the chip-enable control bit are protected. A protected write takes effect only after a magic key has been written to the lock address. Every protected write, whether or not it lands, locks the registers again. A transfer is started with `xfer_req` while `xfer_ready` is high. Completion is signalled by a one-clock `xfer_done` pulse, and for a read the captured byte is then on `xfer_rdata`. When a transfer is marked as a command, new transfers are held off for the programmed busy delay after it.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset `nand_we_n`, `nand_re_n` and `nand_ce_n` are 1, `xfer_done` is 0 and `xfer_ready` is 1. The timing word resets to all zeros, so a write transfer then completes with `xfer_done` high in the 4th clock after the accepting edge (index 3).
- R2: The timing word is laid out as follows. Write-low is bits [3:0], write-high [7:4], read-low [11:8], read-high [15:12], turnaround [18:16], busy [23:19] and CE setup [25:24]. A write transfer holds `nand_we_n` low for write-low+1 clocks after a setup of CE-setup+1 clocks. It then spends write-high+1 clocks high before completing. Counting the first clock after the accepting edge as index 0, `xfer_done` therefore appears at index setup+low+high+3.
- R3: A read transfer uses the read-low and read-high fields and pulses `nand_re_n` instead of `nand_we_n`. It captures `nand_dq_in` on the last clock of the low phase and presents it on `xfer_rdata` when `xfer_done` is high.
- R4: A turnaround gap of turnaround+1 clocks is inserted before the setup phase only when a write transfer follows a read transfer. A read after a write, a read after a read and a write after a write get no gap.
- R5: After a transfer with `xfer_cmd`=1, `xfer_ready` stays low for busy+1 clocks starting with the `xfer_done` clock. A request raised while `xfer_ready` is low is ignored.
- R6: `xfer_done` is exactly one clock wide and follows the last clock of the high phase.
- R7: Writes use `cfg_addr` 0 for the lock, 1 for the timing word and 2 for the chip-enable control. Writing 0x0000A25E to address 0 permits one protected write, to address 1 or 2. Any value other than the key written to address 0 leaves the registers locked. A protected write without a preceding unlock is ignored, and every protected write re-locks.
- R8: Chip-enable control bit 0 set to 1 (the reset value) selects normal mode. In that mode `nand_ce_n` is low only during the setup, low and high phases. Bit 0 set to 0 forces `nand_ce_n` low at all times.
- R9: `nand_we_n` and `nand_re_n` are never low together. During a write strobe `nand_dq_oe` is 1 and `nand_dq_out` carries the request's write byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address: 0 lock, 1 timing, 2 CE control |
| cfg_wdata | input | 32 | Configuration write data |
| xfer_req | input | 1 | Start a one-byte transfer (taken while ready) |
| xfer_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| xfer_cmd | input | 1 | Transfer is a command; apply busy hold-off after it |
| xfer_wdata | input | 8 | Write byte |
| xfer_ready | output | 1 | Sequencer idle and able to accept a request |
| xfer_done | output | 1 | One-clock completion pulse |
| xfer_rdata | output | 8 | Byte captured by the last read |
| nand_dq_in | input | 8 | Data bus from the flash |
| nand_dq_out | output | 8 | Data bus to the flash |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_we_n | output | 1 | Write enable, active low |

## Verification
Some properties hold on every cycle, and the assertions check those: the two strobes are mutually exclusive, `xfer_done` is a one-clock pulse, chip enable covers every strobe, ready is low while a strobe is low, and the write byte stays stable with the output enable on through a write strobe. Phase lengths, the placement of the turnaround gap, the busy hold-off length, read-data capture and the lock behaviour depend on the programmed word and on the order of transfers. Only the bench's scenarios can show these. It measures strobe widths and completion indices against a model, using directed corner cases and random timing words.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  localparam logic [31:0] UNLOCK_KEY = 32'h0000_A25E;

  // Phase counter wide enough for the largest field (busy, 5 bits)
  localparam int PHASE_CNT_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD
  } seq_state_t;

  // Packed MSB first: ce_dly occupies [25:24], wr_lo occupies [3:0]
  typedef struct packed {
    logic [1:0] ce_dly;
    logic [4:0] busy;
    logic [2:0] turn;
    logic [3:0] rd_hi;
    logic [3:0] rd_lo;
    logic [3:0] wr_hi;
    logic [3:0] wr_lo;
  } timing_t;

  localparam int TIMING_W = $bits(timing_t);

endpackage

// File: rtl/nand_strobe_regs.sv
module nand_strobe_regs
  import nand_strobe_pkg::*;
#(
  parameter int              CFG_W        = 32,
  parameter int              ADDR_W       = 2,
  parameter logic [CFG_W-1:0] RESET_TIMING = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output timing_t           timing,
  output logic              ce_normal
);

  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TIMING = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CECTL  = ADDR_W'(2);

  logic unlocked;
  logic unused_hi;

  assign unused_hi = ^cfg_wdata[CFG_W-1:TIMING_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      timing    <= timing_t'(RESET_TIMING[TIMING_W-1:0]);
      ce_normal <= 1'b1;
      unlocked  <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == A_LOCK) begin
        unlocked <= (cfg_wdata == CFG_W'(UNLOCK_KEY));
      end else if (cfg_addr == A_TIMING) begin
        if (unlocked) timing <= timing_t'(cfg_wdata[TIMING_W-1:0]);
        unlocked <= 1'b0;
      end else if (cfg_addr == A_CECTL) begin
        if (unlocked) ce_normal <= cfg_wdata[0];
        unlocked <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_strobe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  timing_t           timing,
  input  logic              ce_normal,
  input  logic              xfer_req,
  input  logic              xfer_rd,
  input  logic              xfer_cmd,
  input  logic [DATA_W-1:0] xfer_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              ce_n,
  output logic              re_n,
  output logic              we_n
);

  localparam int CNT_W = PHASE_CNT_W;

  seq_state_t        st, st_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              rd_q, rd_n, cmd_q, cmd_n;
  logic [DATA_W-1:0] wd_q, wd_n;
  logic              last, active_n;

  assign last = (cnt == '0);

  always_comb begin
    st_n  = st;
    cnt_n = last ? '0 : cnt - CNT_W'(1);
    rd_n  = rd_q;
    cmd_n = cmd_q;
    wd_n  = wd_q;
    unique case (st)
      ST_IDLE: if (xfer_req) begin
        rd_n  = xfer_rd;
        cmd_n = xfer_cmd;
        wd_n  = xfer_wdata;
        // rd_q still holds the direction of the previous transfer
        if (rd_q && !xfer_rd) begin
          st_n  = ST_GAP;
          cnt_n = CNT_W'(timing.turn);
        end else begin
          st_n  = ST_SETUP;
          cnt_n = CNT_W'(timing.ce_dly);
        end
      end
      ST_GAP: if (last) begin
        st_n  = ST_SETUP;
        cnt_n = CNT_W'(timing.ce_dly);
      end
      ST_SETUP: if (last) begin
        st_n  = ST_LOW;
        cnt_n = rd_q ? CNT_W'(timing.rd_lo) : CNT_W'(timing.wr_lo);
      end
      ST_LOW: if (last) begin
        st_n  = ST_HIGH;
        cnt_n = rd_q ? CNT_W'(timing.rd_hi) : CNT_W'(timing.wr_hi);
      end
      ST_HIGH: if (last) begin
        st_n  = cmd_q ? ST_HOLD : ST_IDLE;
        cnt_n = CNT_W'(timing.busy);
      end
      ST_HOLD: if (last) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  assign active_n = (st_n == ST_SETUP) || (st_n == ST_LOW) || (st_n == ST_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      rd_q   <= 1'b0;
      cmd_q  <= 1'b0;
      wd_q   <= '0;
      ready  <= 1'b1;
      done   <= 1'b0;
      rdata  <= '0;
      dq_out <= '0;
      dq_oe  <= 1'b0;
      ce_n   <= 1'b1;
      re_n   <= 1'b1;
      we_n   <= 1'b1;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      rd_q   <= rd_n;
      cmd_q  <= cmd_n;
      wd_q   <= wd_n;
      ready  <= (st_n == ST_IDLE);
      done   <= (st == ST_HIGH) && last;
      dq_out <= wd_n;
      dq_oe  <= active_n && !rd_n;
      ce_n   <= ce_normal ? !active_n : 1'b0;
      we_n   <= !((st_n == ST_LOW) && !rd_n);
      re_n   <= !((st_n == ST_LOW) && rd_n);
      if ((st == ST_LOW) && last && rd_q) rdata <= dq_in;
    end
  end

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_strobe_pkg::*;
#(
  parameter int               DATA_W       = 8,
  parameter int               CFG_W        = 32,
  parameter int               ADDR_W       = 2,
  parameter logic [CFG_W-1:0] RESET_TIMING = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              xfer_req,
  input  logic              xfer_rd,
  input  logic              xfer_cmd,
  input  logic [DATA_W-1:0] xfer_wdata,
  output logic              xfer_ready,
  output logic              xfer_done,
  output logic [DATA_W-1:0] xfer_rdata,
  input  logic [DATA_W-1:0] nand_dq_in,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  output logic              nand_ce_n,
  output logic              nand_re_n,
  output logic              nand_we_n
);

  timing_t timing;
  logic    ce_normal;

  nand_strobe_regs #(
    .CFG_W       (CFG_W),
    .ADDR_W      (ADDR_W),
    .RESET_TIMING(RESET_TIMING)
  ) i_regs (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .timing   (timing),
    .ce_normal(ce_normal)
  );

  nand_strobe_seq #(
    .DATA_W(DATA_W)
  ) i_seq (
    .clk       (clk),
    .rst       (rst),
    .timing    (timing),
    .ce_normal (ce_normal),
    .xfer_req  (xfer_req),
    .xfer_rd   (xfer_rd),
    .xfer_cmd  (xfer_cmd),
    .xfer_wdata(xfer_wdata),
    .dq_in     (nand_dq_in),
    .ready     (xfer_ready),
    .done      (xfer_done),
    .rdata     (xfer_rdata),
    .dq_out    (nand_dq_out),
    .dq_oe     (nand_dq_oe),
    .ce_n      (nand_ce_n),
    .re_n      (nand_re_n),
    .we_n      (nand_we_n)
  );

endmodule

// File: rtl/nand_strobe_chk.sv
module nand_strobe_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_ready,
  input logic              xfer_done,
  input logic              nand_ce_n,
  input logic              nand_re_n,
  input logic              nand_we_n,
  input logic              nand_dq_oe,
  input logic [DATA_W-1:0] nand_dq_out
);

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  assert_ce_covers_R8: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

  assert_busy_not_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n) |-> !xfer_ready);

  assert_oe_on_write_R9: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> nand_dq_oe);

  assert_wdata_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |=> (nand_we_n || $stable(nand_dq_out)));

  assert_done_ends_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (nand_we_n && nand_re_n));

endmodule

bind nand_strobe_gen nand_strobe_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_nand_strobe_gen.sv
module test_nand_strobe_gen;

  localparam logic [31:0] KEY = 32'h0000_A25E;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        xfer_req = 1'b0, xfer_rd = 1'b0, xfer_cmd = 1'b0;
  logic [7:0]  xfer_wdata = '0, nand_dq_in = '0;
  logic        xfer_ready, xfer_done, nand_dq_oe, nand_ce_n, nand_re_n, nand_we_n;
  logic [7:0]  xfer_rdata, nand_dq_out;

  always #5 clk = ~clk;

  nand_strobe_gen i_nand_strobe_gen (.*);

  int n_chk = 0;
  int n_err = 0;

  // bench model of the protected registers
  logic [25:0] m_tw = '0;
  bit          m_unl = 1'b0;
  bit          m_ce = 1'b1;
  bit          m_last_rd = 1'b0;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_done(logic [25:0] tw, bit rd, bit prev_rd);
    int gap;
    gap = (prev_rd && !rd) ? int'(tw[18:16]) + 1 : 0;
    return gap + int'(tw[25:24]) + 3 +
           (rd ? int'(tw[11:8]) + int'(tw[15:12]) : int'(tw[3:0]) + int'(tw[7:4]));
  endfunction

  function automatic int exp_low(logic [25:0] tw, bit rd);
    return rd ? int'(tw[11:8]) + 1 : int'(tw[3:0]) + 1;
  endfunction

  function automatic logic [31:0] pack_tw(int wl, int wh, int rl, int rh, int ta, int bz, int ce);
    return 32'(wl) | (32'(wh) << 4) | (32'(rl) << 8) | (32'(rh) << 12) |
           (32'(ta) << 16) | (32'(bz) << 19) | (32'(ce) << 24);
  endfunction

  task automatic cfg_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 2'd0) m_unl = (d == KEY);
    else if (a == 2'd1) begin if (m_unl) m_tw = d[25:0]; m_unl = 1'b0; end
    else if (a == 2'd2) begin if (m_unl) m_ce = d[0]; m_unl = 1'b0; end
  endtask

  task automatic program_tw(logic [31:0] d);
    cfg_wr(2'd0, KEY);
    cfg_wr(2'd1, d);
  endtask

  // One transfer; measures completion index, strobe widths, busy hold-off
  task automatic xfer(string tag, bit rd, bit cmd, logic [7:0] d, bit poke);
    int k, low, wrong, dqerr, cebad, b, edone;
    @(negedge clk);
    while (!xfer_ready) @(negedge clk);
    xfer_req = 1'b1; xfer_rd = rd; xfer_cmd = cmd; xfer_wdata = d; nand_dq_in = d;
    @(negedge clk);
    xfer_req = 1'b0;
    k = 0; low = 0; wrong = 0; dqerr = 0; cebad = 0;
    while (!xfer_done && k < 500) begin
      if (rd ? !nand_re_n : !nand_we_n) low++;
      if (rd ? !nand_we_n : !nand_re_n) wrong++;
      if (!nand_we_n && (nand_dq_out != d || !nand_dq_oe)) dqerr++;
      if ((!nand_we_n || !nand_re_n) && nand_ce_n) cebad++;
      @(negedge clk);
      k++;
    end
    edone = exp_done(m_tw, rd, m_last_rd);
    check(tag, "done index", k, edone);
    check(rd ? "R3" : "R2", "strobe low clocks", low, exp_low(m_tw, rd));
    check("R9", "wrong strobe / dq errors", wrong + dqerr, 0);
    check("R8", "strobe without CE", cebad, 0);
    if (rd) check("R3", "read data", int'(xfer_rdata), int'(d));
    b = 0;
    while (!xfer_ready && b < 100) begin
      if (poke && b == 0) begin xfer_req = 1'b1; xfer_rd = 1'b0; xfer_cmd = 1'b0; end
      @(negedge clk);
      xfer_req = 1'b0;
      b++;
    end
    check("R5", "busy hold clocks", b, cmd ? int'(m_tw[23:19]) + 1 : 0);
    m_last_rd = rd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int stray;
    logic [31:0] tw_a;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "we_n", int'(nand_we_n), 1);
    check("R1", "re_n", int'(nand_re_n), 1);
    check("R1", "ce_n", int'(nand_ce_n), 1);
    check("R1", "done", int'(xfer_done), 0);
    check("R1", "ready", int'(xfer_ready), 1);
    xfer("R1", 1'b0, 1'b0, 8'h5A, 1'b0);

    tw_a = pack_tw(3, 2, 5, 1, 4, 6, 2);
    // R7 write without unlock is ignored
    cfg_wr(2'd1, tw_a);
    xfer("R7", 1'b0, 1'b0, 8'hC3, 1'b0);
    // R7 wrong key does not unlock
    cfg_wr(2'd0, 32'h0000_A25F);
    cfg_wr(2'd1, tw_a);
    xfer("R7", 1'b0, 1'b0, 8'h11, 1'b0);
    // R7 key then write applies
    program_tw(tw_a);
    xfer("R2", 1'b0, 1'b0, 8'h96, 1'b0);
    // R7 the next write re-locked
    cfg_wr(2'd1, 32'h0);
    xfer("R7", 1'b0, 1'b0, 8'h3C, 1'b0);

    // R4 turnaround placement
    xfer("R3", 1'b1, 1'b0, 8'hA5, 1'b0);
    xfer("R4", 1'b1, 1'b0, 8'h0F, 1'b0);
    xfer("R4", 1'b0, 1'b0, 8'hF0, 1'b0);
    xfer("R4", 1'b0, 1'b0, 8'h77, 1'b0);
    xfer("R4", 1'b1, 1'b0, 8'h88, 1'b0);

    // R5 command busy hold, stray request ignored
    xfer("R5", 1'b0, 1'b1, 8'h70, 1'b1);
    stray = 0;
    repeat (6) begin
      @(negedge clk);
      if (!nand_we_n || !nand_re_n || !xfer_ready) stray++;
    end
    check("R5", "request during hold ignored", stray, 0);

    // R8 chip-enable control
    cfg_wr(2'd0, KEY);
    cfg_wr(2'd2, 32'h0);
    @(negedge clk);
    check("R8", "ce_n forced low when idle", int'(nand_ce_n), 0);
    xfer("R8", 1'b0, 1'b0, 8'h42, 1'b0);
    cfg_wr(2'd2, 32'h1);
    @(negedge clk);
    check("R8", "locked write ignored, ce_n still low", int'(nand_ce_n), 0);
    cfg_wr(2'd0, KEY);
    cfg_wr(2'd2, 32'h1);
    @(negedge clk);
    check("R8", "ce_n high when idle in normal mode", int'(nand_ce_n), 1);

    // R2/R3/R4/R5 random timing words and transfers
    for (int it = 0; it < 25; it++) begin
      program_tw($urandom() & 32'h03FF_FFFF);
      for (int j = 0; j < 4; j++) begin
        bit r;
        r = 1'($urandom() % 2);
        xfer(r ? "R3" : "R2", r, ($urandom() % 4) == 0, 8'($urandom()), 1'b0);
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule